// File: doc/BRIEF.md
# Indirect Branch Fetch Gate

This block sits in the front end of a simple in-order fetch pipeline. It decides, for every indirect branch that decode hands it, whether fetch may go on and to which address. Two target registers are tracked: the link register, which serves returns, and the count register, which serves computed jumps. For each register the block counts the writes that have been issued but not yet completed. It also keeps a copy of the last value written and owns a single rename slot. A small return-address stack is filled by calls.

Decode offers one branch event at a time over a valid/ready handshake. Two cases resolve at once and give a one-cycle pulse on the target-valid output. One is a target register with no pending write. The other is an unconditional return that may be predicted from the stack. Any other case raises a registered stall and holds the handshake until a completing write or a resolved condition releases it. A misprediction flush drops every speculative record and rewinds the stack to its state just before the last accepted branch.

Top module: `indirect_branch_gate`

## Requirements
- R1: After reset, br_ready_o is 1, stall_o and tgt_valid_o are 0, and both register copies hold zero.
- R2: br_lr_i selects the register: 1 is the link register and 0 is the count register. A branch accepted while its register has no pending write gives tgt_valid_o=1 on the next cycle. tgt_o is then the data of the most recent completed write to that register, whether or not the branch is conditional.
- R3: A count-register branch accepted while a count-register write is pending gives stall_o=1 and br_ready_o=0 from the next cycle. The last pending write completes in some cycle. In the cycle after it, stall_o is 0 and tgt_valid_o is 1 with tgt_o equal to that write's data.
- R4: An unconditional link-register branch accepted under three conditions gives no stall. tgt_valid_o is 1 on the next cycle, with tgt_o equal to the most recently pushed address still on the stack. The three conditions are: a link-register write is pending, the rename slot is free, and the stack is not empty.
- R5: The return-address stack holds 4 entries in last-in first-out order. Each call pushes call_ret_addr_i. A push onto a full stack discards the oldest entry. Every accepted link-register branch pops one entry if the stack is not empty.
- R6: An unconditional link-register branch that finds a pending link write and an empty stack stalls. The stall lasts until the pending link writes complete, and the target is then the last write's data.
- R7: A conditional link-register branch that finds a pending link write always stalls. A resolved not-taken condition releases it on the next cycle with tgt_valid_o=0. A resolved taken condition keeps the stall until the link writes complete, and the target is then the write data.
- R8: A link-register branch that is predicted from the stack occupies the rename slot until all link writes complete. A further unconditional link-register branch accepted while the slot is occupied stalls until then.
- R9: On the cycle after flush_i, stall_o and tgt_valid_o are 0 and br_ready_o is 1. The flush clears all pending-write counts and the rename slot. It restores the stack to its depth and top from before the last accepted branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Misprediction flush |
| lr_wr_issue_i | input | 1 | Link-register write issued |
| lr_wr_done_i | input | 1 | Link-register write completed |
| lr_wr_data_i | input | 32 | Data of the completed link-register write |
| ctr_wr_issue_i | input | 1 | Count-register write issued |
| ctr_wr_done_i | input | 1 | Count-register write completed |
| ctr_wr_data_i | input | 32 | Data of the completed count-register write |
| call_i | input | 1 | Call decoded; push a return address |
| call_ret_addr_i | input | 32 | Return address to push |
| br_valid_i | input | 1 | Indirect branch event valid |
| br_ready_o | output | 1 | Gate can accept a branch event |
| br_lr_i | input | 1 | 1: link-register branch, 0: count-register branch |
| br_cond_i | input | 1 | Branch carries a condition |
| cond_resolved_i | input | 1 | Condition of the held branch is now known |
| cond_taken_i | input | 1 | Resolved condition value |
| stall_o | output | 1 | Fetch must stall |
| tgt_valid_o | output | 1 | Target on tgt_o is valid this cycle |
| tgt_o | output | 32 | Target address for fetch |

## Verification
A stale pending-write count shows up at the ports on the next branch to that register. A wrongly cleared count gives a target with no stall where a stall is required. A count left set gives a stall where none is expected. Either is visible one cycle after the branch is accepted. A fault in the stack pointer or its checkpoint returns the wrong address on the next predicted return. A rename slot that fails to clear stalls a later return that should be predicted. Each of these is caught on the first return that depends on it.

// File: rtl/ibg_pkg.sv
package ibg_pkg;
  typedef enum logic {
    BR_CTR = 1'b0,
    BR_LR  = 1'b1
  } br_kind_e;
endpackage

// File: rtl/ibg_pend.sv
// Pending-write counter and architectural copy for one target register.
module ibg_pend #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          issue_i,
  input  logic          done_i,
  input  logic [DW-1:0] done_data_i,
  output logic          busy_o,
  output logic          clr_o,
  output logic [DW-1:0] val_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] val_q;

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i) cnt_d = '0;
    else if (issue_i && !done_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else if (done_i && !issue_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      val_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (done_i) val_q <= done_data_i;
    end
  end

  // busy/value as seen after this cycle's events
  assign busy_o = (cnt_d != '0);
  assign clr_o  = (cnt_q != '0) && (cnt_d == '0) && !flush_i;
  assign val_o  = done_i ? done_data_i : val_q;

  assert_issue_pends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !flush_i |=> cnt_q != '0);
endmodule

// File: rtl/ibg_ras.sv
// Circular return-address stack with single checkpoint.
module ibg_ras #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  input  logic          ckpt_i,
  input  logic          restore_i,
  output logic [AW-1:0] top_o,
  output logic          empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] SP_LAST = PW'(DEPTH - 1);
  localparam logic [NW-1:0] N_FULL  = NW'(DEPTH);

  logic [DEPTH-1:0][AW-1:0] mem_q;
  logic [PW-1:0] sp_q, cp_sp_q, sp_nxt, sp_prv;
  logic [NW-1:0] cnt_q, cp_cnt_q;
  logic          do_pop;

  assign sp_nxt = (sp_q == SP_LAST) ? '0 : sp_q + 1'b1;
  assign sp_prv = (sp_q == '0) ? SP_LAST : sp_q - 1'b1;
  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      sp_q     <= '0;
      cnt_q    <= '0;
      cp_sp_q  <= '0;
      cp_cnt_q <= '0;
    end else if (restore_i) begin
      sp_q  <= cp_sp_q;
      cnt_q <= cp_cnt_q;
    end else begin
      if (ckpt_i) begin
        cp_sp_q  <= sp_q;
        cp_cnt_q <= cnt_q;
      end
      if (push_i && do_pop) begin
        mem_q[sp_q] <= push_addr_i;
      end else if (push_i) begin
        mem_q[sp_nxt] <= push_addr_i;
        sp_q          <= sp_nxt;
        if (cnt_q != N_FULL) cnt_q <= cnt_q + 1'b1;
      end else if (do_pop) begin
        sp_q  <= sp_prv;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign top_o   = mem_q[sp_q];
  assign empty_o = (cnt_q == '0);

  assert_push_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !restore_i |=> !empty_o);
endmodule

// File: rtl/ibg_ctrl.sv
// Accept/hold decision, rename slot and registered outputs.
module ibg_ctrl
  import ibg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          br_valid_i,
  input  logic          br_lr_i,
  input  logic          br_cond_i,
  input  logic          cond_resolved_i,
  input  logic          cond_taken_i,
  input  logic          lr_busy_i,
  input  logic          lr_clr_i,
  input  logic [AW-1:0] lr_val_i,
  input  logic          ctr_busy_i,
  input  logic          ctr_clr_i,
  input  logic [AW-1:0] ctr_val_i,
  input  logic          ras_empty_i,
  input  logic [AW-1:0] ras_top_i,
  output logic          ras_pop_o,
  output logic          ras_ckpt_o,
  output logic          br_ready_o,
  output logic          stall_o,
  output logic          tgt_valid_o,
  output logic [AW-1:0] tgt_o
);
  br_kind_e      kind_q, kind_d, kind_in;
  logic          wait_q, wait_d, cond_q, cond_d, spec_q, spec_d, tv_q, tv_d, acc;
  logic [AW-1:0] tgt_q, tgt_d;

  assign kind_in    = br_kind_e'(br_lr_i);
  assign acc        = br_valid_i && !wait_q && !flush_i;
  assign ras_pop_o  = acc && (kind_in == BR_LR);
  assign ras_ckpt_o = acc;

  always_comb begin
    wait_d = wait_q;
    kind_d = kind_q;
    cond_d = cond_q;
    spec_d = spec_q;
    tv_d   = 1'b0;
    tgt_d  = tgt_q;
    if (wait_q) begin
      if (kind_q == BR_CTR) begin
        if (ctr_clr_i) begin
          wait_d = 1'b0; tv_d = 1'b1; tgt_d = ctr_val_i;
        end
      end else if (lr_clr_i) begin
        wait_d = 1'b0; tv_d = 1'b1; tgt_d = lr_val_i;
      end else if (cond_q && cond_resolved_i) begin
        if (!cond_taken_i) wait_d = 1'b0;
        else               cond_d = 1'b0;
      end
    end else if (acc) begin
      kind_d = kind_in;
      cond_d = br_cond_i;
      if (kind_in == BR_CTR) begin
        if (ctr_busy_i) wait_d = 1'b1;
        else begin tv_d = 1'b1; tgt_d = ctr_val_i; end
      end else if (!lr_busy_i) begin
        tv_d = 1'b1; tgt_d = lr_val_i;
      end else if (br_cond_i || spec_q || ras_empty_i) begin
        wait_d = 1'b1;
      end else begin
        tv_d = 1'b1; tgt_d = ras_top_i; spec_d = 1'b1;
      end
    end
    if (lr_clr_i) spec_d = 1'b0;
    if (flush_i) begin
      wait_d = 1'b0; cond_d = 1'b0; spec_d = 1'b0; tv_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      kind_q <= BR_CTR;
      cond_q <= 1'b0;
      spec_q <= 1'b0;
      tv_q   <= 1'b0;
      tgt_q  <= '0;
    end else begin
      wait_q <= wait_d;
      kind_q <= kind_d;
      cond_q <= cond_d;
      spec_q <= spec_d;
      tv_q   <= tv_d;
      tgt_q  <= tgt_d;
    end
  end

  assign br_ready_o  = !wait_q;
  assign stall_o     = wait_q;
  assign tgt_valid_o = tv_q;
  assign tgt_o       = tgt_q;

  assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !stall_o && !tgt_valid_o);
  assert_release_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) && !$past(flush_i) |-> $past(ctr_clr_i || lr_clr_i || cond_resolved_i));
  assert_stall_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(lr_busy_i || ctr_busy_i));
endmodule

// File: rtl/indirect_branch_gate.sv
module indirect_branch_gate #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned RAS_DEPTH = 4,
  parameter int unsigned PEND_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              lr_wr_issue_i,
  input  logic              lr_wr_done_i,
  input  logic [ADDR_W-1:0] lr_wr_data_i,
  input  logic              ctr_wr_issue_i,
  input  logic              ctr_wr_done_i,
  input  logic [ADDR_W-1:0] ctr_wr_data_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_ret_addr_i,
  input  logic              br_valid_i,
  output logic              br_ready_o,
  input  logic              br_lr_i,
  input  logic              br_cond_i,
  input  logic              cond_resolved_i,
  input  logic              cond_taken_i,
  output logic              stall_o,
  output logic              tgt_valid_o,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int unsigned NREG = 2; // 0: count register, 1: link register

  logic [NREG-1:0]             iss, dn, busy, clr;
  logic [NREG-1:0][ADDR_W-1:0] dat, val;
  logic [ADDR_W-1:0]           ras_top;
  logic                        ras_empty, ras_pop, ras_ckpt;

  assign iss = {lr_wr_issue_i, ctr_wr_issue_i};
  assign dn  = {lr_wr_done_i,  ctr_wr_done_i};
  assign dat = {lr_wr_data_i,  ctr_wr_data_i};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    ibg_pend #(.DW(ADDR_W), .CW(PEND_W)) u_pend (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush_i),
      .issue_i     (iss[g]),
      .done_i      (dn[g]),
      .done_data_i (dat[g]),
      .busy_o      (busy[g]),
      .clr_o       (clr[g]),
      .val_o       (val[g])
    );
  end

  ibg_ras #(.AW(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (call_i && !flush_i),
    .push_addr_i (call_ret_addr_i),
    .pop_i       (ras_pop),
    .ckpt_i      (ras_ckpt),
    .restore_i   (flush_i),
    .top_o       (ras_top),
    .empty_o     (ras_empty)
  );

  ibg_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .flush_i         (flush_i),
    .br_valid_i      (br_valid_i),
    .br_lr_i         (br_lr_i),
    .br_cond_i       (br_cond_i),
    .cond_resolved_i (cond_resolved_i),
    .cond_taken_i    (cond_taken_i),
    .lr_busy_i       (busy[1]),
    .lr_clr_i        (clr[1]),
    .lr_val_i        (val[1]),
    .ctr_busy_i      (busy[0]),
    .ctr_clr_i       (clr[0]),
    .ctr_val_i       (val[0]),
    .ras_empty_i     (ras_empty),
    .ras_top_i       (ras_top),
    .ras_pop_o       (ras_pop),
    .ras_ckpt_o      (ras_ckpt),
    .br_ready_o      (br_ready_o),
    .stall_o         (stall_o),
    .tgt_valid_o     (tgt_valid_o),
    .tgt_o           (tgt_o)
  );
endmodule

// File: tb/tb_indirect_branch_gate.sv
`timescale 1ns/1ps
module tb_indirect_branch_gate;
  logic        clk_i = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic        lr_wr_issue_i = 1'b0, lr_wr_done_i = 1'b0, ctr_wr_issue_i = 1'b0, ctr_wr_done_i = 1'b0;
  logic [31:0] lr_wr_data_i = '0, ctr_wr_data_i = '0, call_ret_addr_i = '0;
  logic        call_i = 1'b0, br_valid_i = 1'b0, br_lr_i = 1'b0, br_cond_i = 1'b0;
  logic        cond_resolved_i = 1'b0, cond_taken_i = 1'b0;
  logic        br_ready_o, stall_o, tgt_valid_o;
  logic [31:0] tgt_o;

  int total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  indirect_branch_gate dut (.*);

  // reference stack model
  logic [31:0] m_stk [4];
  int m_sp = 0, m_cnt = 0;
  function automatic void m_push(logic [31:0] a);
    m_sp = (m_sp + 1) % 4; m_stk[m_sp] = a; if (m_cnt < 4) m_cnt++;
  endfunction
  function automatic logic [31:0] m_pop();
    logic [31:0] t = m_stk[m_sp];
    if (m_cnt > 0) begin m_sp = (m_sp + 3) % 4; m_cnt--; end
    return t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask
  task automatic call(logic [31:0] a);
    call_i = 1; call_ret_addr_i = a; cyc(); call_i = 0; m_push(a);
  endtask
  task automatic issue(logic lr);
    lr_wr_issue_i = lr; ctr_wr_issue_i = !lr; cyc(); lr_wr_issue_i = 0; ctr_wr_issue_i = 0;
  endtask
  task automatic done(logic lr, logic [31:0] d);
    if (lr) begin lr_wr_done_i = 1; lr_wr_data_i = d; end
    else begin ctr_wr_done_i = 1; ctr_wr_data_i = d; end
    cyc(); lr_wr_done_i = 0; ctr_wr_done_i = 0;
  endtask
  task automatic br(logic lr, logic cnd);
    br_valid_i = 1; br_lr_i = lr; br_cond_i = cnd; cyc(); br_valid_i = 0; br_cond_i = 0;
  endtask
  task automatic resolve(logic tk);
    cond_resolved_i = 1; cond_taken_i = tk; cyc(); cond_resolved_i = 0; cond_taken_i = 0;
  endtask
  task automatic flush();
    flush_i = 1; cyc(); flush_i = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    void'($urandom(32'h5eed_0042));
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    chk("R1 ready", {31'b0, br_ready_o}, 1);
    chk("R1 stall", {31'b0, stall_o}, 0);
    chk("R1 tgt_valid", {31'b0, tgt_valid_o}, 0);
    br(0, 0);
    chk("R1 ctr copy zero", tgt_o, 0);

    // R2: no pending write
    done(0, 32'h0000_1000);
    br(0, 1);
    chk("R2 ctr valid", {31'b0, tgt_valid_o}, 1);
    chk("R2 ctr target", tgt_o, 32'h0000_1000);
    done(1, 32'h0000_2000);
    br(1, 1);
    chk("R2 lr cond no stall", {31'b0, stall_o}, 0);
    chk("R2 lr target", tgt_o, 32'h0000_2000);

    // R3: count register waits for write
    issue(0);
    br(0, 0);
    chk("R3 stall", {31'b0, stall_o}, 1);
    chk("R3 ready low", {31'b0, br_ready_o}, 0);
    chk("R3 no target", {31'b0, tgt_valid_o}, 0);
    cyc();
    chk("R3 still stalled", {31'b0, stall_o}, 1);
    done(0, 32'h0000_3000);
    chk("R3 released", {31'b0, stall_o}, 0);
    chk("R3 target valid", {31'b0, tgt_valid_o}, 1);
    chk("R3 target", tgt_o, 32'h0000_3000);
    cyc();
    chk("R3 pulse one cycle", {31'b0, tgt_valid_o}, 0);

    // R4/R5/R8: stack prediction, overwrite, single slot
    for (int i = 1; i <= 5; i++) call(32'hA000_0000 + i);
    issue(1);
    br(1, 0);
    chk("R4 no stall", {31'b0, stall_o}, 0);
    chk("R4 predicted", tgt_o, 32'hA000_0005);
    void'(m_pop());
    br(1, 0);
    chk("R8 second return stalls", {31'b0, stall_o}, 1);
    void'(m_pop());
    done(1, 32'h0000_4000);
    chk("R8 released target", tgt_o, 32'h0000_4000);
    chk("R8 ready again", {31'b0, br_ready_o}, 1);
    issue(1); br(1, 0);
    chk("R5 lifo third", tgt_o, 32'hA000_0003); void'(m_pop());
    done(1, 32'h0000_4100);
    issue(1); br(1, 0);
    chk("R5 lifo second", tgt_o, 32'hA000_0002); void'(m_pop());
    done(1, 32'h0000_4180);
    issue(1); br(1, 0);
    chk("R5 oldest overwritten, R6 stall", {31'b0, stall_o}, 1);
    done(1, 32'h0000_4200);
    chk("R6 target", tgt_o, 32'h0000_4200);

    // R7: conditional return
    issue(1); br(1, 1);
    chk("R7 cond stalls", {31'b0, stall_o}, 1);
    resolve(1);
    chk("R7 taken keeps stall", {31'b0, stall_o}, 1);
    done(1, 32'h0000_5000);
    chk("R7 taken target", tgt_o, 32'h0000_5000);
    issue(1); br(1, 1);
    resolve(0);
    chk("R7 not-taken release", {31'b0, stall_o}, 0);
    chk("R7 not-taken no target", {31'b0, tgt_valid_o}, 0);
    done(1, 32'h0000_5100);

    // R9: flush
    call(32'hB000_0001); call(32'hB000_0002);
    issue(1); br(1, 0);
    chk("R9 pre-flush predict", tgt_o, 32'hB000_0002);
    flush();
    chk("R9 stall low", {31'b0, stall_o}, 0);
    chk("R9 tgt_valid low", {31'b0, tgt_valid_o}, 0);
    issue(1); br(1, 0);
    chk("R9 stack restored", tgt_o, 32'hB000_0002); void'(m_pop());
    done(1, 32'h0000_6000);
    br(1, 0); void'(m_pop());
    chk("R9 arch after flush", tgt_o, 32'h0000_6000);
    issue(0); br(0, 0);
    flush();
    chk("R9 flush ends stall", {31'b0, stall_o}, 0);
    chk("R9 ready", {31'b0, br_ready_o}, 1);
    br(0, 0);
    chk("R9 pend cleared", tgt_o, 32'h0000_3000);

    // random: calls then returns with a pending link write
    e = 32'h0000_6000;
    for (int it = 0; it < 60; it++) begin
      int n = $urandom_range(0, 6);
      logic hit;
      for (int k = 0; k < n; k++) call($urandom());
      issue(1); br(1, 0);
      hit = (m_cnt > 0);
      if (hit) begin
        d = m_pop();
        chk("R4 random predict", tgt_o, d);
        chk("R4 random no stall", {31'b0, stall_o}, 0);
      end else begin
        chk("R6 random stall", {31'b0, stall_o}, 1);
      end
      d = $urandom();
      done(1, d);
      e = d;
      if (hit) chk("R8 random slot free", {31'b0, stall_o}, 0);
      else chk("R6 random target", tgt_o, d);
      if ($urandom_range(0, 1) == 1) begin
        br(1, 1'($urandom_range(0, 1)));
        void'(m_pop());
        chk("R2 random arch", tgt_o, e);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule